// File: doc/BRIEF.md
# Hierarchical Interrupt Cause Aggregator

This block gathers level status flags from a two-port line interface and folds them into one interrupt line through a three-level tree. At the bottom are sticky cause registers. Each protocol layer has a pair of them: one records that a condition began (a rising edge of its status level) and the other records that the condition went away (a falling edge). Every cause register has a mask of equal width. Unmasked cause bits reduce by OR into per-port transmit and receive summaries and a general summary. Those summaries, together with the interface-error and general-input cause registers, reduce into a top-level register that drives `irq`.

Software reaches the block over a synchronous address/data bus with one cycle of read latency. It unmasks the causes it wants and reads down the tree from the top-level register to the cause register. It then clears bits by writing ones to them. Summary and top-level values are computed, not stored, so clearing the last contributing cause bit drops every bit above it in the same cycle.

Status levels are grouped into 8-bit level groups, `lvl_in[g*8 +: 8]`. For port p (0 or 1), group 4p is the transmit cell/packet layer, 4p+1 is receive section/line, 4p+2 is receive pointer/path and 4p+3 is receive cell/packet layer. Group 8 is general events, 9 is transmit interface error, 10 is receive interface error and 11 is general-purpose inputs.

Top module: `irqagg_top`

## Requirements
- R1: A 0-to-1 change of a status bit sets the same bit position in its onset cause register. Cause register index d (0 to 20) lives at address d. For port p, the onset registers are 8p (transmit), 8p+2 (section/line), 8p+4 (pointer/path) and 8p+6 (receive cell/packet layer). General onset is 16. The rising-edge-only registers are 18 (tx interface error), 19 (rx interface error) and 20 (general inputs).
- R2: A 1-to-0 change of a status bit sets the same bit position in the termination register, whose index is the onset index plus one (8p+1, 8p+3, 8p+5, 8p+7 and 17).
- R3: Cause bits are sticky. A bus write of data D to a cause address clears exactly the bits that are 1 in D.
- R4: If an edge sets a bit in the same cycle that a write clears that bit, the bit stays set.
- R5: Mask register d is at address 0x20+d, and reset sets every mask bit to 1. A mask bit of 1 keeps its cause bit out of every summary. The cause bit still captures and reads back.
- R6: The transmit summary of port p, at address 0x48+p, has bit 0 = OR of unmasked bits of register 8p and bit 1 = OR of unmasked bits of register 8p+1.
- R7: The receive summary of port p, at address 0x50+p, has bits 0..5 = OR of unmasked bits of registers 8p+2 .. 8p+7, in that order.
- R8: The general summary at address 0x58 has bit 0 = OR of unmasked register 16 and bit 1 = OR of unmasked register 17.
- R9: The top-level register at address 0x40 has bit p = any bit of port p's transmit or receive summary. Bit 2 is tx interface error, bit 3 is rx interface error, bit 4 is general inputs and bit 5 is any general summary bit. Clearing the last contributing cause clears it in the same cycle.
- R10: `irq` is a register: it is 1 exactly in the cycle after one in which any top-level bit is 1.
- R11: `bus_rdata` shows the addressed register one clock after `bus_rd` is sampled high and holds its value while `bus_rd` is low.
- R12: After reset every cause bit reads 0, the top-level register reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_in | input | 96 | Twelve 8-bit status level groups |
| bus_addr | input | 7 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data (clear pattern or mask value) |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high registered interrupt |

## Verification
The functions that can collide are edge capture and software clear on the same cause bit. To provoke this, the bench arms a pointer/path onset bit, drops its status level and then, on a single clock edge, raises the level again while writing a one to that bit's position. It then reads the register and expects the bit still set, because the new edge must win. It confirms separately that a clear with no edge present does empty the bit, and that the top-level bit and `irq` fall once it does.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int CAUSE_PER_PORT = 8;
  localparam int GROUP_PER_PORT = 4;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;

  // level group that feeds cause register d
  function automatic int cause_group(input int d, input int nport);
    if (d < CAUSE_PER_PORT * nport + 2) return d / 2;
    return GROUP_PER_PORT * nport + 1 + (d - CAUSE_PER_PORT * nport - 2);
  endfunction

  function automatic edge_kind_e cause_edge(input int d, input int nport);
    if (d < CAUSE_PER_PORT * nport + 2 && (d % 2) == 1) return EDGE_FALL;
    return EDGE_RISE;
  endfunction
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q, prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/irqagg_cell.sv
module irqagg_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] cap_d, mask_d;

  always_comb begin
    cap_d  = (cap_q & ~clr) | ev;
    mask_d = mask_we ? mask_wd : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      mask_q <= '1;
    end else begin
      cap_q  <= cap_d;
      if (mask_we) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/irqagg_tree.sv
module irqagg_tree #(
  parameter int NPORT = 2,
  parameter int W     = 8,
  parameter int NCAUSE = 8 * NPORT + 5,
  parameter int TOPW  = NPORT + 4
) (
  input  logic [NCAUSE-1:0][W-1:0] live,
  output logic [NPORT-1:0][1:0]    tx_sum,
  output logic [NPORT-1:0][5:0]    rx_sum,
  output logic [1:0]               gen_sum,
  output logic [TOPW-1:0]          top
);
  localparam int GBASE = 8 * NPORT;
  logic [NCAUSE-1:0] any_c;

  for (genvar d = 0; d < NCAUSE; d++) begin : g_any
    assign any_c[d] = |live[d];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign tx_sum[p] = any_c[8*p+1 : 8*p];
    assign rx_sum[p] = any_c[8*p+7 : 8*p+2];
    assign top[p]    = (|tx_sum[p]) | (|rx_sum[p]);
  end

  assign gen_sum        = any_c[GBASE+1 : GBASE];
  assign top[NPORT]     = any_c[GBASE+2];
  assign top[NPORT+1]   = any_c[GBASE+3];
  assign top[NPORT+2]   = any_c[GBASE+4];
  assign top[NPORT+3]   = |gen_sum;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
  parameter int NPORT = 2,
  parameter int W     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [(4*NPORT+4)*W-1:0]        lvl_in,
  input  logic [6:0]                      bus_addr,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [W-1:0]                    bus_wdata,
  output logic [W-1:0]                    bus_rdata,
  output logic                            irq
);
  import irqagg_pkg::*;

  localparam int NGRP   = GROUP_PER_PORT * NPORT + 4;
  localparam int NCAUSE = CAUSE_PER_PORT * NPORT + 5;
  localparam int TOPW   = NPORT + 4;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NGRP-1:0][W-1:0]   lvl, rise, fall;
  logic [NCAUSE-1:0][W-1:0] det_q, mask_q, clr_v, live;
  logic [NCAUSE-1:0]        mask_we;
  logic [NPORT-1:0][1:0]    tx_sum;
  logic [NPORT-1:0][5:0]    rx_sum;
  logic [1:0]               gen_sum;
  logic [TOPW-1:0]          top_v;
  logic [1:0]               region;
  logic [4:0]               idx;

  assign lvl    = lvl_in;
  assign region = bus_addr[6:5];
  assign idx    = bus_addr[4:0];

  for (genvar g = 0; g < NGRP; g++) begin : g_edge
    irqagg_edge #(.W(W)) u_edge (
      .clk(clk), .rst_n(rst_n_s), .lvl(lvl[g]), .rise(rise[g]), .fall(fall[g])
    );
  end

  for (genvar d = 0; d < NCAUSE; d++) begin : g_cause
    localparam int SRC = cause_group(d, NPORT);
    logic [W-1:0] ev;
    if (cause_edge(d, NPORT) == EDGE_FALL) begin : g_f
      assign ev = fall[SRC];
    end else begin : g_r
      assign ev = rise[SRC];
    end
    assign clr_v[d]   = (bus_wr && region == 2'd0 && idx == 5'(d)) ? bus_wdata : '0;
    assign mask_we[d] = bus_wr && region == 2'd1 && idx == 5'(d);
    irqagg_cell #(.W(W)) u_cell (
      .clk(clk), .rst_n(rst_n_s), .ev(ev), .clr(clr_v[d]),
      .mask_we(mask_we[d]), .mask_wd(bus_wdata),
      .cap_q(det_q[d]), .mask_q(mask_q[d])
    );
    assign live[d] = det_q[d] & ~mask_q[d];
  end

  irqagg_tree #(.NPORT(NPORT), .W(W), .NCAUSE(NCAUSE), .TOPW(TOPW)) u_tree (
    .live(live), .tx_sum(tx_sum), .rx_sum(rx_sum), .gen_sum(gen_sum), .top(top_v)
  );

  // read path
  logic [W-1:0] rd_mux, rdata_d, rdata_q;
  logic         irq_d, irq_q;

  always_comb begin
    rd_mux = '0;
    unique case (region)
      2'd0: for (int d = 0; d < NCAUSE; d++) if (idx == 5'(d)) rd_mux = det_q[d];
      2'd1: for (int d = 0; d < NCAUSE; d++) if (idx == 5'(d)) rd_mux = mask_q[d];
      2'd2: begin
        unique case (bus_addr[4:3])
          2'd0: if (bus_addr[2:0] == 3'd0) rd_mux = W'(top_v);
          2'd1: for (int p = 0; p < NPORT; p++)
                  if (bus_addr[2:0] == 3'(p)) rd_mux = W'(tx_sum[p]);
          2'd2: for (int p = 0; p < NPORT; p++)
                  if (bus_addr[2:0] == 3'(p)) rd_mux = W'(rx_sum[p]);
          default: if (bus_addr[2:0] == 3'd0) rd_mux = W'(gen_sum);
        endcase
      end
      default: rd_mux = '0;
    endcase
    rdata_d = bus_rd ? rd_mux : rdata_q;
    irq_d   = |top_v;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rdata_d;
      irq_q <= irq_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int NPORT = 2,
  parameter int W     = 8
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic [4*NPORT+3:0][W-1:0]                lvl,
  input logic [8*NPORT+4:0][W-1:0]                det_q,
  input logic [8*NPORT+4:0][W-1:0]                mask_q,
  input logic [8*NPORT+4:0][W-1:0]                clr,
  input logic [NPORT+3:0]                         top,
  input logic                                     irq,
  input logic                                     bus_rd,
  input logic [W-1:0]                             bus_rdata
);
  import irqagg_pkg::*;
  localparam int NCAUSE = 8 * NPORT + 5;
  localparam int NGRP   = 4 * NPORT + 4;

  logic [NGRP-1:0][W-1:0] lvl_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_seen <= '0;
    else        lvl_seen <= lvl;
  end

  for (genvar d = 0; d < NCAUSE; d++) begin : g_d
    localparam int SRC = cause_group(d, NPORT);
    // R3: a held bit only drops when the bus cleared it
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((det_q[d] & $past(det_q[d] & ~clr[d])) == $past(det_q[d] & ~clr[d])));
    if (cause_edge(d, NPORT) == EDGE_RISE) begin : g_on
      // R1: a rising status bit lands in its onset register next cycle
      a_r1_onset: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((det_q[d] & $past(lvl[SRC] & ~lvl_seen[SRC])) ==
                  $past(lvl[SRC] & ~lvl_seen[SRC])));
    end
  end

  // R5: with every mask set nothing reaches the top level
  a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> (top == '0));

  // R10: interrupt is the registered OR of the top level
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|top)));

  // R11: read data holds while no read is issued
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind irqagg_top irqagg_chk #(.NPORT(NPORT), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .lvl(lvl), .det_q(det_q), .mask_q(mask_q),
  .clr(clr_v), .top(top_v), .irq(irq), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;
  localparam int NPORT = 2;
  localparam int W = 8;
  localparam int NCAUSE = 8 * NPORT + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [(4*NPORT+4)*W-1:0] lvl_r = '0;
  logic [6:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic irq;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic rd_pend = 1'b0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irqagg_top #(.NPORT(NPORT), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl_r), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: compare read results one clock after the strobe
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic rd(input logic [6:0] a, input logic [W-1:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic setlvl(input int g, input int b, input logic v);
    @(negedge clk);
    lvl_r[g*W+b] = v;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk); @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state, R5 masks reset to ones
    rd(7'h00, 8'h00, "R12 cause0");
    rd(7'h40, 8'h00, "R12 top");
    rd(7'h2C, 8'hFF, "R5 mask reset");
    total++;
    if (irq !== 1'b0) begin bad++; $display("FAIL R12: irq=%b expected=0", irq); end

    for (int d = 0; d < NCAUSE; d++) wr(7'(32 + d), 8'h00);

    // R1 onset, R6 tx summary, R9 top, R10 irq
    setlvl(0, 3, 1'b1);
    rd(7'h00, 8'h08, "R1 tx onset");
    rd(7'h01, 8'h00, "R2 no end yet");
    rd(7'h48, 8'h01, "R6 tx sum");
    rd(7'h40, 8'h01, "R9 port0 bit");
    chk_irq(1'b1, "R10 irq rise");

    // R2 termination
    setlvl(0, 3, 1'b0);
    rd(7'h01, 8'h08, "R2 tx end");
    rd(7'h48, 8'h03, "R6 tx sum both");

    // R3 write-one-to-clear
    wr(7'h00, 8'h08);
    rd(7'h00, 8'h00, "R3 clear onset");
    rd(7'h48, 8'h02, "R6 sum after clear");
    wr(7'h01, 8'h08);
    rd(7'h40, 8'h00, "R9 top cleared");
    chk_irq(1'b0, "R10 irq fall");

    // R7 rx summary on port 1 pointer/path
    setlvl(6, 7, 1'b1);
    rd(7'h0C, 8'h80, "R1 ptr onset");
    rd(7'h51, 8'h04, "R7 rx sum");
    rd(7'h40, 8'h02, "R9 port1 bit");

    // R5 mask blocks summary but keeps capture
    wr(7'h2C, 8'h80);
    rd(7'h40, 8'h00, "R5 masked top");
    rd(7'h0C, 8'h80, "R5 masked still held");
    chk_irq(1'b0, "R5 masked irq");
    wr(7'h2C, 8'h00);
    rd(7'h40, 8'h02, "R5 unmasked top");

    // R4 set wins over clear in the same cycle
    setlvl(6, 7, 1'b0);
    rd(7'h51, 8'h0C, "R7 rx sum onset+end");
    @(negedge clk);
    lvl_r[6*W+7] = 1'b1;
    bus_wr = 1'b1; bus_addr = 7'h0C; bus_wdata = 8'h80;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(7'h0C, 8'h80, "R4 set beats clear");
    wr(7'h0D, 8'h80);
    rd(7'h0D, 8'h00, "R3 clear end");
    wr(7'h0C, 8'h80);
    rd(7'h0C, 8'h00, "R3 clear no edge");
    rd(7'h40, 8'h00, "R9 top empty");

    // R9 general input and R8 general summary
    setlvl(11, 0, 1'b1);
    rd(7'h14, 8'h01, "R1 gpin onset");
    rd(7'h40, 8'h10, "R9 gpin bit");
    setlvl(8, 2, 1'b1);
    rd(7'h10, 8'h04, "R1 gen onset");
    rd(7'h58, 8'h01, "R8 gen sum");
    rd(7'h40, 8'h30, "R9 gen bit");
    setlvl(8, 2, 1'b0);
    rd(7'h58, 8'h03, "R8 gen sum both");
    rd(7'h11, 8'h04, "R2 gen end");

    // R11 rdata holds without a read
    repeat (3) @(negedge clk);
    total++;
    if (bus_rdata !== 8'h04) begin
      bad++; $display("FAIL R11: rdata=%h expected=04", bus_rdata);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule